// File: doc/BRIEF.md
# Masked Record Search Engine

This block collects a 128-bit search key from a 64-bit input stream, two accepted beats per key. It then walks a table of 64 fixed-width records of 20 bytes each, held in on-chip memory. Each record is judged through twenty compare lanes. Lane j takes record byte j and sets it against one key byte, chosen per lane by a programmable map entry. A per-lane enable bit drops any lane out of the test. Key bytes that carry single-bit flags are left out simply by not mapping any enabled lane onto them.

The scan reads one record per cycle, lowest index first, and stops at the first record whose enabled lanes all agree. It then raises `done` for one cycle, together with a found flag and the record index. While a scan is running the stream input is held off. Writes to the table and to the lane configuration are dropped during that time, so one search always sees one consistent table.

Top module: `mrec_search`

## Requirements
- R1: A beat is accepted when `in_valid` and `in_ready` are both high. The first accepted beat of a key supplies key bytes 0..7 and the second supplies key bytes 8..15. Key byte k of a beat sits at word bits [8k+7:8k].
- R2: `in_ready` is high whenever no scan is running. It is low from the edge that accepts the second key word until the cycle in which `done` is raised. Beats offered while it is low are not taken and do not disturb the next key.
- R3: Lane j compares record byte j (bits [8j+7:8j] of `tbl_wdata` as written) with key byte `map[j]`. A disabled lane always agrees. An enabled lane whose map value is 16 or more never agrees. A record matches when all 20 lanes agree.
- R4: When several records match, the lowest index is reported with `found` = 1.
- R5: When no record matches, `done` comes with `found` = 0 and `index` = 0.
- R6: `done` is high for exactly one cycle. Counting from the edge that accepts the second key word, it is high after rising edge i+2 for a match at index i. With no match it is high after rising edge 65.
- R7: A table write (`tbl_we`, `tbl_addr`, `tbl_wdata`) is dropped while a scan is running. A write made in the same cycle as the second key word is stored, and the scan that starts next sees it.
- R8: A configuration write (`cfg_we`) sets the enable bit and the map value of lane `cfg_lane`. It is dropped while a scan is running.
- R9: After reset all lanes are disabled with map value 0, `in_ready` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Key word offered |
| in_data | input | 64 | Key word |
| in_ready | output | 1 | Key word can be taken |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Record index to write |
| tbl_wdata | input | 160 | Record contents, byte j at [8j+7:8j] |
| cfg_we | input | 1 | Lane configuration write strobe |
| cfg_lane | input | 5 | Lane being configured |
| cfg_en | input | 1 | Lane enable value |
| cfg_map | input | 5 | Key byte selected by the lane |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A record matched |
| index | output | 6 | Index of the matching record, 0 if none |

## Verification
Two of this block's functions can fall in the same clock edge: a table write and the acceptance of the final key word that starts the scan. A table write or configuration write can also arrive in the middle of a scan. The bench provokes the first case by writing a copy of a later record into a low slot on the very cycle of the second key beat. The reported index must be that low slot, which shows the write landed before the first read. It provokes the second case by overwriting the target record or disabling a lane mid-scan. It then checks that the result is unchanged in that scan and again in the following one.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [0:0] {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;

endpackage

// File: rtl/mrs_key_gather.sv
module mrs_key_gather #(
   parameter  int unsigned WORD_W    = 64,
   parameter  int unsigned KEY_BYTES = 16,
   localparam int unsigned KEY_W     = KEY_BYTES * mrs_pkg::BYTE_W,
   localparam int unsigned BEATS     = KEY_W / WORD_W,
   localparam int unsigned BCNT_W    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_valid,
   input  logic [WORD_W-1:0] beat_data,
   input  logic              beat_ready,
   input  logic              hold_i,
   output logic [KEY_W-1:0]  key_o,
   output logic              key_full_o
);

   if ((KEY_W % WORD_W) != 0 || BEATS < 1) begin : g_bad_width
      $fatal(1, "key width must be a whole number of input words");
   end

   logic [BCNT_W-1:0] beat_q;
   logic [WORD_W-1:0] seg_q [BEATS];
   logic              take;
   logic              last_beat;

   assign take      = beat_valid & beat_ready;
   assign last_beat = (beat_q == BCNT_W'(BEATS - 1));
   assign key_full_o = take & last_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (take) begin
         beat_q <= last_beat ? '0 : beat_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < BEATS; b++) seg_q[b] <= '0;
      end else begin
         for (int b = 0; b < BEATS; b++) begin
            if (take && beat_q == BCNT_W'(b)) seg_q[b] <= beat_data;
         end
      end
   end

   for (genvar b = 0; b < BEATS; b++) begin : g_pack
      assign key_o[b*WORD_W +: WORD_W] = seg_q[b];
   end

   // R2
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(key_o));

endmodule

// File: rtl/mrs_rec_store.sv
module mrs_rec_store #(
   parameter  int unsigned REC_W   = 160,
   parameter  int unsigned DEPTH   = 64,
   parameter  bit          USE_LUT = 1'b0,
   localparam int unsigned ADDR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REC_W-1:0]  wr_data,
   input  logic              lock_i,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REC_W-1:0]  rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_idx
);

   if (DEPTH < 2) begin : g_bad_depth
      $fatal(1, "record table needs at least two entries");
   end

   logic [REC_W-1:0] mem_q [DEPTH];
   logic             wr_fire;

   assign wr_fire = wr_en & ~lock_i & (32'(wr_addr) < DEPTH);

   always_ff @(posedge clk) begin
      if (wr_fire) mem_q[wr_addr] <= wr_data;
   end

   if (USE_LUT) begin : g_lut
      assign rd_data  = mem_q[rd_addr];
      assign rd_valid = rd_en;
      assign rd_idx   = rd_addr;
   end else begin : g_bram
      logic [REC_W-1:0]  data_q;
      logic              vld_q;
      logic [ADDR_W-1:0] idx_q;

      always_ff @(posedge clk) begin
         if (rd_en) data_q <= mem_q[rd_addr];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            idx_q <= '0;
         end else begin
            vld_q <= rd_en;
            if (rd_en) idx_q <= rd_addr;
         end
      end

      assign rd_data  = data_q;
      assign rd_valid = vld_q;
      assign rd_idx   = idx_q;
   end

   // R7
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock_i) |=> (mem_q[$past(wr_addr)] == $past(mem_q[wr_addr])));

endmodule

// File: rtl/mrs_lane_match.sv
module mrs_lane_match #(
   parameter  int unsigned KEY_BYTES = 16,
   parameter  int unsigned REC_BYTES = 20,
   parameter  int unsigned MAP_W     = 5,
   localparam int unsigned LANE_W    = $clog2(REC_BYTES),
   localparam int unsigned KIDX_W    = $clog2(KEY_BYTES),
   localparam int unsigned KEY_W     = KEY_BYTES * mrs_pkg::BYTE_W,
   localparam int unsigned REC_W     = REC_BYTES * mrs_pkg::BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [LANE_W-1:0] cfg_lane,
   input  logic              cfg_en,
   input  logic [MAP_W-1:0]  cfg_map,
   input  logic              lock_i,
   input  logic [KEY_W-1:0]  key_i,
   input  logic [REC_W-1:0]  rec_i,
   output logic              hit_o
);

   if (KEY_BYTES < 2 || MAP_W < KIDX_W) begin : g_bad_map
      $fatal(1, "map field too narrow for the key");
   end

   logic [REC_BYTES-1:0]            en_q;
   logic [REC_BYTES-1:0][MAP_W-1:0] map_q;
   logic [REC_BYTES-1:0]            lane_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         map_q <= '0;
      end else if (cfg_we && !lock_i && (32'(cfg_lane) < REC_BYTES)) begin
         en_q[cfg_lane]  <= cfg_en;
         map_q[cfg_lane] <= cfg_map;
      end
   end

   for (genvar j = 0; j < REC_BYTES; j++) begin : g_lane
      logic [7:0] kbyte;
      logic [7:0] rbyte;
      logic       in_rng;
      assign in_rng     = (32'(map_q[j]) < KEY_BYTES);
      assign kbyte      = key_i[32'(map_q[j][KIDX_W-1:0]) * 8 +: 8];
      assign rbyte      = rec_i[j*8 +: 8];
      assign lane_eq[j] = ~en_q[j] | (in_rng & (kbyte == rbyte));
   end

   assign hit_o = &lane_eq;

   // R8
   cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && lock_i) |=> ($stable(en_q) && $stable(map_q)));

endmodule

// File: rtl/mrec_search.sv
module mrec_search #(
   parameter  int unsigned WORD_W    = 64,
   parameter  int unsigned KEY_BYTES = 16,
   parameter  int unsigned REC_BYTES = 20,
   parameter  int unsigned DEPTH     = 64,
   parameter  int unsigned MAP_W     = 5,
   parameter  bit          USE_LUT   = 1'b0,
   localparam int unsigned ADDR_W    = $clog2(DEPTH),
   localparam int unsigned LANE_W    = $clog2(REC_BYTES),
   localparam int unsigned REC_W     = REC_BYTES * mrs_pkg::BYTE_W,
   localparam int unsigned KEY_W     = KEY_BYTES * mrs_pkg::BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   input  logic              tbl_we,
   input  logic [ADDR_W-1:0] tbl_addr,
   input  logic [REC_W-1:0]  tbl_wdata,
   input  logic              cfg_we,
   input  logic [LANE_W-1:0] cfg_lane,
   input  logic              cfg_en,
   input  logic [MAP_W-1:0]  cfg_map,
   output logic              done,
   output logic              found,
   output logic [ADDR_W-1:0] index
);

   import mrs_pkg::*;

   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

   scan_state_e       st_q;
   logic              busy;
   logic [KEY_W-1:0]  key_w;
   logic              key_full;
   logic              iss_on_q;
   logic [ADDR_W-1:0] iss_addr_q;
   logic [REC_W-1:0]  rec_data;
   logic              rec_valid;
   logic [ADDR_W-1:0] rec_idx;
   logic              hit;

   assign busy     = (st_q == SCAN_RUN);
   assign in_ready = ~busy;

   mrs_key_gather #(.WORD_W(WORD_W), .KEY_BYTES(KEY_BYTES)) i_gather (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (in_valid),
      .beat_data  (in_data),
      .beat_ready (in_ready),
      .hold_i     (busy),
      .key_o      (key_w),
      .key_full_o (key_full)
   );

   mrs_rec_store #(.REC_W(REC_W), .DEPTH(DEPTH), .USE_LUT(USE_LUT)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_addr  (tbl_addr),
      .wr_data  (tbl_wdata),
      .lock_i   (busy),
      .rd_en    (iss_on_q),
      .rd_addr  (iss_addr_q),
      .rd_data  (rec_data),
      .rd_valid (rec_valid),
      .rd_idx   (rec_idx)
   );

   mrs_lane_match #(.KEY_BYTES(KEY_BYTES), .REC_BYTES(REC_BYTES), .MAP_W(MAP_W)) i_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_lane (cfg_lane),
      .cfg_en   (cfg_en),
      .cfg_map  (cfg_map),
      .lock_i   (busy),
      .key_i    (key_w),
      .rec_i    (rec_data),
      .hit_o    (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SCAN_IDLE;
         iss_on_q   <= 1'b0;
         iss_addr_q <= '0;
         done       <= 1'b0;
         found      <= 1'b0;
         index      <= '0;
      end else begin
         done <= 1'b0;
         case (st_q)
            SCAN_IDLE: begin
               if (key_full) begin
                  st_q       <= SCAN_RUN;
                  iss_on_q   <= 1'b1;
                  iss_addr_q <= '0;
               end
            end
            SCAN_RUN: begin
               if (iss_on_q) begin
                  iss_addr_q <= iss_addr_q + 1'b1;
                  if (iss_addr_q == LAST_IDX) iss_on_q <= 1'b0;
               end
               if (rec_valid) begin
                  if (hit) begin
                     done     <= 1'b1;
                     found    <= 1'b1;
                     index    <= rec_idx;
                     st_q     <= SCAN_IDLE;
                     iss_on_q <= 1'b0;
                  end else if (rec_idx == LAST_IDX) begin
                     done     <= 1'b1;
                     found    <= 1'b0;
                     index    <= '0;
                     st_q     <= SCAN_IDLE;
                     iss_on_q <= 1'b0;
                  end
               end
            end
            default: st_q <= SCAN_IDLE;
         endcase
      end
   end

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R5
   miss_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !found) |-> (index == '0));

   // R4
   hit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> $past(hit && rec_valid));

endmodule

// File: tb/test_mrec_search.sv
`timescale 1ns/1ps
module test_mrec_search;

   localparam int DEPTH = 64;
   localparam int RB    = 20;
   localparam int KB    = 16;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [63:0]  in_data;
   logic         in_ready;
   logic         tbl_we;
   logic [5:0]   tbl_addr;
   logic [159:0] tbl_wdata;
   logic         cfg_we;
   logic [4:0]   cfg_lane;
   logic         cfg_en;
   logic [4:0]   cfg_map;
   logic         done;
   logic         found;
   logic [5:0]   index;

   always #10 clk = ~clk;

   mrec_search i_mrec_search (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
      .cfg_we(cfg_we), .cfg_lane(cfg_lane), .cfg_en(cfg_en), .cfg_map(cfg_map),
      .done(done), .found(found), .index(index)
   );

   int n_chk  = 0;
   int n_fail = 0;

   logic [159:0] mt [DEPTH];
   bit           m_en [RB];
   int           m_map [RB];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] gen_byte(int r, int j);
      return 8'((r * 37 + j * 11 + 5) ^ (j * 16));
   endfunction

   function automatic bit lane_ok(logic [159:0] rec, logic [127:0] key, int j);
      if (!m_en[j]) return 1'b1;
      if (m_map[j] >= KB) return 1'b0;
      return rec[8*j +: 8] == key[8*m_map[j] +: 8];
   endfunction

   function automatic int model_search(logic [127:0] key);
      for (int r = 0; r < DEPTH; r++) begin
         bit ok = 1'b1;
         for (int j = 0; j < RB; j++) if (!lane_ok(mt[r], key, j)) ok = 1'b0;
         if (ok) return r;
      end
      return -1;
   endfunction

   function automatic logic [127:0] key_for(int t);
      logic [127:0] k = {16{8'hA5}};
      for (int j = 0; j < RB; j++)
         if (m_en[j] && m_map[j] < KB) k[8*m_map[j] +: 8] = mt[t][8*j +: 8];
      return k;
   endfunction

   task automatic put_rec(input int a, input logic [159:0] d);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 6'(a); tbl_wdata = d;
      @(negedge clk);
      tbl_we = 1'b0;
      mt[a] = d;
   endtask

   task automatic put_cfg(input int l, input bit e, input int m);
      @(negedge clk);
      cfg_we = 1'b1; cfg_lane = 5'(l); cfg_en = e; cfg_map = 5'(m);
      @(negedge clk);
      cfg_we = 1'b0;
      m_en[l] = e; m_map[l] = m;
   endtask

   // act: 0 none, 1 table write mid-scan, 2 stray beats mid-scan,
   //      3 config write mid-scan, 4 table write with the second key word
   task automatic run_search(input logic [127:0] key, input int act,
                             input int a_addr, input logic [159:0] a_data,
                             input int c_lane, input bit c_en, input int c_map,
                             output bit f, output int idx, output int lat,
                             output bit pulse_ok, output bit rdy_low);
      @(negedge clk);
      in_valid = 1'b1; in_data = key[63:0];
      @(negedge clk);
      in_data = key[127:64];
      if (act == 4) begin tbl_we = 1'b1; tbl_addr = 6'(a_addr); tbl_wdata = a_data; end
      @(negedge clk);
      in_valid = 1'b0; tbl_we = 1'b0;
      lat = 0; rdy_low = 1'b1;
      if (act == 2) begin in_valid = 1'b1; in_data = '1; end
      forever begin
         @(negedge clk);
         lat++;
         if (done) begin
            in_valid = 1'b0; tbl_we = 1'b0; cfg_we = 1'b0;
            break;
         end
         if (lat == 3) begin
            rdy_low = !in_ready;
            if (act == 1) begin tbl_we = 1'b1; tbl_addr = 6'(a_addr); tbl_wdata = a_data; end
            if (act == 3) begin
               cfg_we = 1'b1; cfg_lane = 5'(c_lane); cfg_en = c_en; cfg_map = 5'(c_map);
            end
         end else if (lat == 4) begin
            tbl_we = 1'b0; cfg_we = 1'b0;
         end
         if (lat >= 300) begin
            in_valid = 1'b0; tbl_we = 1'b0; cfg_we = 1'b0;
            break;
         end
      end
      f   = found;
      idx = int'(index);
      @(negedge clk);
      pulse_ok = !done;
   endtask

   task automatic expect_search(input logic [127:0] key, input string req, input int act,
                                input int a_addr, input logic [159:0] a_data,
                                input int c_lane, input bit c_en, input int c_map);
      bit f, p, r;
      int idx, lat;
      int e = model_search(key);
      int el = (e < 0) ? DEPTH + 1 : e + 2;
      run_search(key, act, a_addr, a_data, c_lane, c_en, c_map, f, idx, lat, p, r);
      chk(f == (e >= 0), {req, " found"}, int'(f), int'(e >= 0));
      chk(idx == ((e < 0) ? 0 : e), {req, " index"}, idx, (e < 0) ? 0 : e);
      chk(lat == el, {req, " R6 latency"}, lat, el);
      chk(p, {req, " R6 pulse"}, int'(!p), 0);
      chk(r, {req, " R2 ready low"}, int'(!r), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [127:0] k;
      int lanes [6] = '{2, 3, 4, 6, 7, 11};
      int maps  [6] = '{1, 5, 9, 10, 12, 15};
      int v;
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
      tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
      cfg_we = 1'b0; cfg_lane = '0; cfg_en = 1'b0; cfg_map = '0;
      for (int j = 0; j < RB; j++) begin m_en[j] = 1'b0; m_map[j] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(in_ready == 1'b1, "R9 ready after reset", int'(in_ready), 1);
      chk(done == 1'b0, "R9 done after reset", int'(done), 0);

      for (int r = 0; r < DEPTH; r++) begin
         logic [159:0] d;
         for (int j = 0; j < RB; j++) d[8*j +: 8] = gen_byte(r, j);
         put_rec(r, d);
      end

      // R9 / R3: all lanes disabled after reset, so record 0 matches any key
      expect_search(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, "R9 R3 all lanes off", 0, 0, '0, 0, 0, 0);

      for (int i = 0; i < 6; i++) put_cfg(lanes[i], 1'b1, maps[i]);

      // R4: a later duplicate of an earlier record resolves to the earlier index
      put_rec(50, mt[10]);

      // R1 R3 R4: sweep every record as the target
      for (int t = 0; t < DEPTH; t++) expect_search(key_for(t), "R1 R3 R4 sweep", 0, 0, '0, 0, 0, 0);

      // R5: value absent from lane 2 of every record
      v = 0;
      for (int c = 0; c < 256; c++) begin
         bit used = 1'b0;
         for (int r = 0; r < DEPTH; r++) if (mt[r][23:16] == 8'(c)) used = 1'b1;
         if (!used) begin v = c; break; end
      end
      k = key_for(0);
      k[15:8] = 8'(v);
      chk(model_search(k) < 0, "R5 miss key prepared", model_search(k), -1);
      expect_search(k, "R5 no match", 0, 0, '0, 0, 0, 0);

      // R2: stray beats during a scan are not taken
      expect_search(k, "R2 stray beats", 2, 0, '0, 0, 0, 0);
      expect_search(key_for(33), "R2 R1 next key intact", 0, 0, '0, 0, 0, 0);

      // R7: write during scan is dropped, in this scan and the next
      expect_search(key_for(40), "R7 write mid-scan", 1, 40, '0, 0, 0, 0);
      expect_search(key_for(40), "R7 table unchanged", 0, 0, '0, 0, 0, 0);

      // R7: write together with the second key word is seen by the scan
      k = key_for(30);
      mt[5] = mt[30];
      expect_search(k, "R7 write with last beat", 4, 5, mt[30], 0, 0, 0);

      // R8: config write during scan is dropped
      k = key_for(20);
      k[15:8] = 8'(v);
      expect_search(k, "R8 cfg mid-scan", 3, 0, '0, 2, 1'b0, 0);
      expect_search(k, "R8 cfg unchanged", 0, 0, '0, 0, 0, 0);
      put_cfg(2, 1'b0, 1);
      expect_search(k, "R8 cfg write idle", 0, 0, '0, 0, 0, 0);
      put_cfg(2, 1'b1, 1);

      // R3: enabled lane mapped past the key never agrees
      put_cfg(0, 1'b1, 20);
      expect_search(key_for(12), "R3 map out of range", 0, 0, '0, 0, 0, 0);
      put_cfg(0, 1'b0, 0);
      expect_search(key_for(12), "R3 lane restored", 0, 0, '0, 0, 0, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule